// File: doc/BRIEF.md
# Scrambled-State Secure Scan Register

This block stands in for a three-bit section of an ordinary scan chain that covers secret flip-flops. In functional mode (`scan_en` low) every flip-flop loads its bit of the parallel data bus. The capture path is a plain 2:1 mux with no added logic. In scan mode (`scan_en` high) the flip-flops follow a scrambled shift path made of XOR taps and inverters.

Seen from its serial pins, the section behaves exactly like a three-stage shift register: a bit entering `scan_in` leaves `scan_out` three clocks later, whatever state the section held when shifting began. The contents after a shift are not the bits that were shifted in, in any order. A tester that knows the equations can still set any state it wants by shifting (justification) and can read any state back by shifting (observation). A tester that does not know the equations cannot. The rest of the chain can remain a plain shift register. `scan_out` is a combinational function of the state.

Top module: `ssr_secure_scan`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three state bits become 0. In that state `scan_out` is 1.
- R2: With `scan_en` low, each rising edge loads `state_q` from `func_d` bit for bit (bit 0 = first stage, bit 2 = third stage).
- R3: With `scan_en` high, each rising edge loads `state_q[0]` with `scan_in`.
- R4: With `scan_en` high, each rising edge loads `state_q[1]` with the inverse of the previous `state_q[0]`.
- R5: With `scan_en` high, each rising edge loads `state_q[2]` with `scan_in` XOR the previous `state_q[1]`.
- R6: `scan_out` is the XNOR of `state_q[0]` and `state_q[2]`, and it follows the state within the same cycle.
- R7: Once three consecutive shift edges have passed, `scan_out` equals the value that `scan_in` held at the first of those edges. This holds from any starting state.
- R8: From any start state, shifting in a0, a1, a2 (in that order) reaches any target state T, where a0 = NOT(T[0] XOR T[2]), a1 = NOT T[1] and a2 = T[0].
- R9: The start state S can be recovered from the `scan_out` values z0, z1, z2 seen before each of three shifts: S[0] = z2, S[1] = NOT z1, S[2] = z2 XOR NOT z0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | 1 selects the scrambled shift path, 0 selects functional capture |
| scan_in | input | 1 | Serial scan data in |
| func_d | input | 3 | Parallel functional data from the logic kernel |
| state_q | output | 3 | Current flip-flop contents |
| scan_out | output | 1 | Serial scan data out |

## Verification
The delay property assumes that `scan_en` and `rst_n` stay high at all three edges that carry a bit through the section. The assertion therefore only applies when its `$past` history shows three clean shift edges in a row. The capture and per-stage shift assertions need only the current cycle to be out of reset. The stimulus changes `scan_en`, `scan_in` and `func_d` only on falling edges. It sets each start state through capture and then keeps `scan_en` high for whole three-bit windows. The one exception is a deliberate reset during a shift, which the gated assertions ignore.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int SSR_STAGES = 3;
  localparam int SSR_DELAY  = SSR_STAGES;
  typedef logic [SSR_STAGES-1:0] ssr_state_t;
endpackage

// File: rtl/ssr_cell.sv
module ssr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_sel,
  input  logic func_bit,
  input  logic scan_bit,
  output logic q
);
  logic d_sel;

  assign d_sel = shift_sel ? scan_bit : func_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_sel;
  end

  // R2: capture path loads the functional bit
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_sel |=> q == $past(func_bit));
endmodule

// File: rtl/ssr_scramble.sv
module ssr_scramble
  import ssr_pkg::*;
(
  input  ssr_state_t cur,
  input  logic       ser_in,
  output ssr_state_t shift_nxt,
  output logic       ser_out
);
  always_comb begin
    shift_nxt[0] = ser_in;
    shift_nxt[1] = ~cur[0];
    shift_nxt[2] = ser_in ^ cur[1];
  end

  assign ser_out = ~(cur[0] ^ cur[2]);
endmodule

// File: rtl/ssr_secure_scan.sv
module ssr_secure_scan
  import ssr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  scan_in,
  input  logic [SSR_STAGES-1:0] func_d,
  output logic [SSR_STAGES-1:0] state_q,
  output logic                  scan_out
);
  ssr_state_t shift_nxt;

  ssr_scramble u_scr (
    .cur       (state_q),
    .ser_in    (scan_in),
    .shift_nxt (shift_nxt),
    .ser_out   (scan_out)
  );

  for (genvar g = 0; g < SSR_STAGES; g++) begin : g_stage
    ssr_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_sel (scan_en),
      .func_bit  (func_d[g]),
      .scan_bit  (shift_nxt[g]),
      .q         (state_q[g])
    );
  end

  // R3: first stage takes the serial input
  a_r3_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> state_q[0] == $past(scan_in));

  // R4: second stage takes the inverted first stage
  a_r4_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> state_q[1] == !$past(state_q[0]));

  // R5: third stage takes input XOR second stage
  a_r5_third_stage: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> state_q[2] == ($past(scan_in) ^ $past(state_q[1])));

  // R7: serial delay of exactly three shift clocks
  a_r7_serial_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(scan_en, 1) &&
     $past(rst_n, 2) && $past(scan_en, 2) &&
     $past(rst_n, 3) && $past(scan_en, 3))
    |-> scan_out == $past(scan_in, 3));
endmodule

// File: tb/ssr_secure_scan_test.sv
module ssr_secure_scan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0;
  logic       scan_in = 1'b0;
  logic [2:0] func_d = 3'b000;
  logic [2:0] state_q;
  logic       scan_out;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  ssr_secure_scan uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_d(func_d), .state_q(state_q), .scan_out(scan_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // capture value v (R2), state observed after the edge
  task automatic capture(input logic [2:0] v);
    @(negedge clk);
    scan_en = 1'b0; func_d = v;
    @(posedge clk); #1;
  endtask

  // one shift; z returns scan_out seen before the edge
  task automatic shift(input logic b, output logic z);
    @(negedge clk);
    scan_en = 1'b1; scan_in = b;
    #1 z = scan_out;
    @(posedge clk); #1;
  endtask

  function automatic logic [2:0] model_shift(input logic [2:0] s, input logic b);
    model_shift = {b ^ s[1], ~s[0], b};
  endfunction

  initial begin
    logic z0, z1, z2, zd;
    logic [2:0] expst;
    logic hist [0:299];
    rst_n = 1'b0; scan_en = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(state_q == 3'b000, "R1 reset state", state_q, 0);
    chk(scan_out == 1'b1, "R1 reset scan_out", scan_out, 1);
    @(negedge clk); rst_n = 1'b1;

    // R2 and R6: capture every value and check the output function
    for (int v = 0; v < 8; v++) begin
      capture(v[2:0]);
      chk(state_q == v[2:0], "R2 capture", state_q, v);
      chk(scan_out == ~(v[0] ^ v[2]), "R6 scan_out function", scan_out, ~(v[0] ^ v[2]) & 1);
    end

    // R3-R5, R7, R8, R9: every start state and every target state
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 8; t++) begin
        logic a0, a1, a2;
        logic [2:0] obs;
        a0 = ~(t[0] ^ t[2]); a1 = ~t[1]; a2 = t[0];
        capture(s[2:0]);
        expst = s[2:0];
        shift(a0, z0); expst = model_shift(expst, a0);
        chk(state_q == expst, "R3 R4 R5 shift step", state_q, expst);
        shift(a1, z1); expst = model_shift(expst, a1);
        chk(state_q == expst, "R3 R4 R5 shift step", state_q, expst);
        shift(a2, z2); expst = model_shift(expst, a2);
        chk(state_q == t[2:0], "R8 justification target", state_q, t);
        chk(scan_out == a0, "R7 three-clock delay", scan_out, a0);
        obs = {z2 ^ ~z0, ~z1, z2};
        chk(obs == s[2:0], "R9 observed start state", obs, s);
      end
    end

    // R7: long random stream from a random start state
    capture(3'($urandom));
    for (int i = 0; i < 300; i++) begin
      hist[i] = 1'($urandom);
      shift(hist[i], zd);
      if (i >= 3) chk(zd == hist[i-3], "R7 random stream", zd, hist[i-3]);
    end

    // R1: reset applied in the middle of shifting
    @(negedge clk); rst_n = 1'b0; scan_en = 1'b1; scan_in = 1'b1;
    @(posedge clk); #1;
    chk(state_q == 3'b000, "R1 reset during shift", state_q, 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule